// File: doc/BRIEF.md
# Windowed Data Address Translator

This block turns a 16-bit data-side address into a physical target and a byte offset. The lower half of the space goes straight to internal data RAM. The top quarter is sparse I/O space. Only one 16-byte group is legal there, and that group also resolves into data RAM. The third quarter (0x8000 to 0xBFFF) is a 16 KiB window. A 16-bit window register decides where the window lands. It can land on a page of instruction memory, or on a 16 KiB slice of one 128 KiB unified-memory segment.

A presence bitmap input tells the block which unified segments exist. An access that reaches an absent segment, or an illegal I/O address, raises a bus-error flag. The flag is raised only while the access-valid input is high. The translation is purely combinational. The only state is the window register, which is written through a simple write-enable port and read back on an output.

Top module: `dwin_xlate`

## Requirements
- R1: After reset the window register reads 0x0000.
- R2: When `winWrEn` is high at a rising edge, `winValue` shows `winWrData` from that edge on. While `winWrEn` is low, `winValue` keeps its value.
- R3: Addresses 0x0000 to 0x7FFF give `tgtSel` = 0 (data RAM), `physAddr` equal to the address, and no bus error.
- R4: Addresses 0xFF00 to 0xFF0F (address bits 15:4 equal to 0xFF0) give `tgtSel` = 0, `physAddr` equal to the address, and no bus error.
- R5: Any other address from 0xC000 to 0xFFFF gives `tgtSel` = 0 and `physAddr` equal to the address, and raises `busErr` when `accValid` is high.
- R6: For addresses 0x8000 to 0xBFFF with window bit 12 set, `tgtSel` = 1 (instruction memory) and `physAddr` = window[3:0] × 0x4000 + address[13:0], with no bus error.
- R7: For addresses 0x8000 to 0xBFFF with window bit 12 clear, `tgtSel` = 2 (unified memory) and `physAddr` = window[9:3] × 0x20000 + window[2:0] × 0x4000 + address[13:0].
- R8: In the case of R7, `busErr` is raised when `accValid` is high and `segPresent[window[9:3]]` is 0.
- R9: `busErr` is never high while `accValid` is low. Translation outputs do not depend on `accValid`.
- R10: Window bits 15:13 and 11:10 have no effect on translation. In instruction-memory mode, bits 11:4 have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winWrEn | input | 1 | Window register write enable |
| winWrData | input | 16 | Value to write into the window register |
| winValue | output | 16 | Current window register contents |
| accValid | input | 1 | The address is a real access this cycle |
| accAddr | input | 16 | Data address to translate |
| segPresent | input | 128 | One bit per unified segment; 1 means the segment exists |
| tgtSel | output | 2 | Target: 0 data RAM, 1 instruction memory, 2 unified memory |
| physAddr | output | 24 | Physical byte offset inside the target |
| busErr | output | 1 | Illegal I/O address or absent segment, qualified by accValid |

## Verification
The hardest case to reach is an access to an absent segment combined with window bits that must be ignored. It needs a write to the window register followed by a window-region access, under a presence map that the bench controls. The bench loads several window values: instruction pages, present and absent segments, and junk in the unused bits. After each write it sweeps all 65536 addresses, several per clock, and in one sweep toggles `accValid` with the address. Every result is compared against arithmetic computed in the bench.

// File: rtl/dwin_pkg.sv
package dwin_pkg;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IMEM = 2'd1,
    TGT_UMEM = 2'd2
  } tgt_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic useImemPage;
    logic useUmemSlice;
  } xlate_strb_t;

endpackage

// File: rtl/dwin_ctrl.sv
module dwin_ctrl
  import dwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MODE_BIT = 12,
  parameter int IO_LEGAL = 12'hFF0,
  parameter int WIN_W    = 16
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accValid,
  input  logic [WIN_W-1:0]  winQ,
  input  logic              segHit,
  output xlate_strb_t       strb,
  output tgt_e              tgtSel,
  output logic              busErr
);
  localparam int TAG_W = ADDR_W - 4;

  logic isIo, isWin, ioLegal;

  always_comb begin
    isIo    = accAddr[ADDR_W-1] & accAddr[ADDR_W-2];
    isWin   = accAddr[ADDR_W-1] & ~accAddr[ADDR_W-2];
    ioLegal = (accAddr[ADDR_W-1:4] == TAG_W'(IO_LEGAL));

    strb.useImemPage  = isWin & winQ[MODE_BIT];
    strb.useUmemSlice = isWin & ~winQ[MODE_BIT];

    if (strb.useImemPage)       tgtSel = TGT_IMEM;
    else if (strb.useUmemSlice) tgtSel = TGT_UMEM;
    else                        tgtSel = TGT_DRAM;

    busErr = accValid & ((isIo & ~ioLegal) | (strb.useUmemSlice & ~segHit));
  end
endmodule

// File: rtl/dwin_dpath.sv
module dwin_dpath
  import dwin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_W   = 16,
  parameter int OFF_W   = 14,
  parameter int PAGE_W  = 4,
  parameter int SLICE_W = 3,
  parameter int SEG_W   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    winWrEn,
  input  logic [WIN_W-1:0]        winWrData,
  output logic [WIN_W-1:0]        winQ,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [(1<<SEG_W)-1:0]   segPresent,
  input  xlate_strb_t             strb,
  output logic                    segHit,
  output logic [SEG_W+SLICE_W+OFF_W-1:0] physAddr
);
  localparam int PHYS_W = SEG_W + SLICE_W + OFF_W;
  localparam int IMEM_W = PAGE_W + OFF_W;

  logic [SEG_W-1:0]   segIdx;
  logic [SLICE_W-1:0] sliceIdx;
  logic [PAGE_W-1:0]  pageIdx;
  logic [OFF_W-1:0]   winOff;

  always_ff @(posedge clk) begin
    if (!rstN)        winQ <= '0;
    else if (winWrEn) winQ <= winWrData;
  end

  always_comb begin
    segIdx   = winQ[SLICE_W +: SEG_W];
    sliceIdx = winQ[SLICE_W-1:0];
    pageIdx  = winQ[PAGE_W-1:0];
    winOff   = accAddr[OFF_W-1:0];
    segHit   = segPresent[segIdx];

    if (strb.useUmemSlice)
      physAddr = {segIdx, sliceIdx, winOff};
    else if (strb.useImemPage)
      physAddr = PHYS_W'({pageIdx, winOff});
    else
      physAddr = PHYS_W'(accAddr);
  end

  // the unused IMEM width is checked against the output width at elaboration
  if (IMEM_W > PHYS_W) begin : g_bad_width
    initial $error("instruction page address wider than physical output");
  end
endmodule

// File: rtl/dwin_xlate.sv
module dwin_xlate
  import dwin_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_W   = 16,
  parameter int OFF_W   = 14,
  parameter int PAGE_W  = 4,
  parameter int SLICE_W = 3,
  parameter int SEG_W   = 7,
  parameter int MODE_BIT = 12,
  localparam int NUM_SEG = 1 << SEG_W,
  localparam int PHYS_W  = SEG_W + SLICE_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winWrEn,
  input  logic [WIN_W-1:0]   winWrData,
  output logic [WIN_W-1:0]   winValue,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [NUM_SEG-1:0] segPresent,
  output logic [1:0]         tgtSel,
  output logic [PHYS_W-1:0]  physAddr,
  output logic               busErr
);
  xlate_strb_t strb;
  tgt_e        tgt;
  logic        segHit;

  dwin_ctrl #(
    .ADDR_W(ADDR_W), .MODE_BIT(MODE_BIT), .WIN_W(WIN_W)
  ) ctrl_i (
    .accAddr(accAddr), .accValid(accValid), .winQ(winValue),
    .segHit(segHit), .strb(strb), .tgtSel(tgt), .busErr(busErr)
  );

  dwin_dpath #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
    .SLICE_W(SLICE_W), .SEG_W(SEG_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .winWrEn(winWrEn), .winWrData(winWrData),
    .winQ(winValue), .accAddr(accAddr), .segPresent(segPresent),
    .strb(strb), .segHit(segHit), .physAddr(physAddr)
  );

  assign tgtSel = tgt;
endmodule

// File: rtl/dwin_xlate_chk.sv
module dwin_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        winWrEn,
  input logic [15:0] winWrData,
  input logic [15:0] winValue,
  input logic        accValid,
  input logic [15:0] accAddr,
  input logic [1:0]  tgtSel,
  input logic [23:0] physAddr,
  input logic        busErr
);
  p_win_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    winWrEn |=> winValue == $past(winWrData));

  p_win_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !winWrEn |=> $stable(winValue));

  p_low_direct_r3: assert property (@(posedge clk) disable iff (!rstN)
    !accAddr[15] |-> (tgtSel == 2'd0 && physAddr == {8'd0, accAddr} && !busErr));

  p_io_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    accAddr[15:4] == 12'hFF0 |-> !busErr);

  p_imem_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accAddr[15:14] == 2'b10 && winValue[12]) |->
      (tgtSel == 2'd1 && physAddr[23:18] == 6'd0 && !busErr));

  p_err_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> accValid);

  p_tgt_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    tgtSel != 2'd3);
endmodule

bind dwin_xlate dwin_xlate_chk chk_i (
  .clk(clk), .rstN(rstN), .winWrEn(winWrEn), .winWrData(winWrData),
  .winValue(winValue), .accValid(accValid), .accAddr(accAddr),
  .tgtSel(tgtSel), .physAddr(physAddr), .busErr(busErr)
);

// File: tb/dwin_xlate_tb_top.sv
module dwin_xlate_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         winWrEn;
  logic [15:0]  winWrData;
  logic [15:0]  winValue;
  logic         accValid;
  logic [15:0]  accAddr;
  logic [127:0] segPresent;
  logic [1:0]   tgtSel;
  logic [23:0]  physAddr;
  logic         busErr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dwin_xlate dut_i (
    .clk(clk), .rstN(rstN), .winWrEn(winWrEn), .winWrData(winWrData),
    .winValue(winValue), .accValid(accValid), .accAddr(accAddr),
    .segPresent(segPresent), .tgtSel(tgtSel), .physAddr(physAddr),
    .busErr(busErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h win=%h actual=%h expected=%h", req, accAddr, winValue, act, exp);
    end
  endtask

  task automatic write_win(input logic [15:0] v);
    @(negedge clk);
    winWrEn = 1'b1; winWrData = v;
    @(negedge clk);
    winWrEn = 1'b0; winWrData = ~v;
    check("R2 load", 32'(winValue), 32'(v));
  endtask

  // expected model and compare for one address
  task automatic check_addr(input logic [15:0] w, input logic v);
    logic [1:0]  eTgt;
    logic [23:0] ePhys;
    logic        eErr;
    string       req;
    if (accAddr <= 16'h7FFF) begin
      req = "R3"; eTgt = 2'd0; ePhys = 24'(accAddr); eErr = 1'b0;
    end else if (accAddr >= 16'hC000) begin
      eTgt = 2'd0; ePhys = 24'(accAddr);
      if (accAddr[15:4] == 12'hFF0) begin req = "R4"; eErr = 1'b0; end
      else begin req = "R5"; eErr = v; end
    end else if (w[12]) begin
      req = "R6 R10"; eTgt = 2'd1;
      ePhys = 24'(w[3:0]) * 24'h4000 + 24'(accAddr[13:0]); eErr = 1'b0;
    end else begin
      req = "R7 R8 R10"; eTgt = 2'd2;
      ePhys = 24'(w[9:3]) * 24'h20000 + 24'(w[2:0]) * 24'h4000 + 24'(accAddr[13:0]);
      eErr = v & ~segPresent[w[9:3]];
    end
    if (!v && busErr) req = {req, " R9"};
    check({req, " tgt"}, 32'(tgtSel), 32'(eTgt));
    check({req, " phys"}, 32'(physAddr), 32'(ePhys));
    check({req, " err"}, 32'(busErr), 32'(eErr));
  endtask

  // full address sweep, four addresses per clock, away from the rising edge
  task automatic sweep(input bit toggleValid);
    logic [15:0] w;
    w = winValue;
    for (int blk = 0; blk < 16384; blk++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        accAddr  = 16'(blk * 4 + k);
        accValid = toggleValid ? ~accAddr[1] : 1'b1;
        #1;
        check_addr(w, accValid);
      end
    end
  endtask

  initial begin
    rstN = 1'b0; winWrEn = 1'b0; winWrData = 16'hFFFF;
    accValid = 1'b0; accAddr = 16'h0;
    for (int i = 0; i < 128; i++) segPresent[i] = (i % 3) != 1;
    repeat (3) @(negedge clk);
    check("R1 reset window", 32'(winValue), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 hold without write", 32'(winValue), 32'h0);

    sweep(1'b0);                 // segment 0 present, slice 0
    sweep(1'b1);                 // R9: valid toggles with address
    write_win(16'h1005);  sweep(1'b0);   // R6 page 5
    write_win(16'h1FFF);  sweep(1'b0);   // R10 page 15, junk in bits 11:4
    write_win(16'h0120);  sweep(1'b0);   // R7 segment 36 present
    write_win(16'hEC05);  sweep(1'b0);   // R10 junk bits, segment 0 slice 5
    write_win(16'h03FF);  sweep(1'b1);   // R8 segment 127 absent

    // R2: write enable low holds the value
    @(negedge clk);
    winWrData = 16'h1234;
    repeat (2) @(negedge clk);
    check("R2 hold", 32'(winValue), 32'h03FF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule